// File: doc/BRIEF.md
# Crystal Oscillator Startup Delay Timer

This block decides when a freshly started crystal oscillator may be treated as stable. It runs in the oscillator's own clock domain. Once the oscillator is both switched on and not paused, it counts whole units of 256 oscillator periods until a programmed number of units has passed. Then it raises a stable flag and holds it for as long as the oscillator stays on and awake. Switching the oscillator off or pausing it drops the flag at once and clears all count state, so the next start always waits the full delay.

Software sets the delay through a small configuration word that lives in the register clock domain. The word carries a 14-bit unit count and a times-four stretch bit. It leaves reset at 196 units (about 50,000 oscillator cycles) with the stretch off. The oscillator domain treats the word as quasi-static: software changes it only while the oscillator is off. The stable flag goes back to the register domain through a chain of synchroniser flops, where it is meant to be read as the top bit of a status word.

Top module: `osc_startup_timer`

## Requirements
- R1: While reg_rst is high, the configuration readback becomes 0x000000C4 on the next reg_clk edge. That value is a delay of 196 units with the stretch bit clear.
- R2: A reg_clk edge with cfg_we high loads cfg_wdata bits 13:0 as the delay and bit 20 as the stretch bit. The readback shows them in the same positions, and every other readback bit reads 0 whatever was written there.
- R3: With the stretch bit clear and delay D > 0, osc_stable rises on the 256*D-th osc_clk edge at which osc_enable is high and osc_pause is low, counting from the first such edge.
- R4: With the stretch bit set and delay D > 0, osc_stable rises on the 1024*D-th such edge.
- R5: A delay of zero behaves as one unit: osc_stable rises on the 256th such edge, with or without the stretch bit.
- R6: An osc_clk edge with osc_enable low clears osc_stable and the count. After re-enabling, the full delay is counted again.
- R7: An osc_clk edge with osc_pause high clears osc_stable and the count in the same way. After waking, the full delay is counted again.
- R8: Once high, osc_stable stays high on every edge for as long as osc_enable stays high and osc_pause stays low.
- R9: status_stable reproduces osc_stable through two reg_clk flops. When both clocks are the same clock, it is osc_stable delayed by two edges, and it is 0 while reg_rst is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register-domain clock |
| reg_rst | input | 1 | Synchronous active-high reset, register domain |
| cfg_we | input | 1 | Write strobe for the startup configuration word |
| cfg_wdata | input | 32 | Write data: delay in 13:0, stretch in 20 |
| cfg_rdata | output | 32 | Configuration readback |
| status_stable | output | 1 | Synchronised stable flag for status bit 31 |
| osc_clk | input | 1 | Oscillator clock |
| osc_rst | input | 1 | Synchronous active-high reset, oscillator domain |
| osc_enable | input | 1 | Oscillator is switched on |
| osc_pause | input | 1 | Oscillator is paused (dormant) |
| osc_stable | output | 1 | Stable flag in the oscillator domain |

## Verification
A fault in the prescaler or the unit counter does not show while counting is under way. It appears only when the flag rises, early or late by a whole unit or more. For that reason the bench checks the flag on the edge just before the expected rise and on the rise edge itself, for delays of zero, small values, the reset value and the stretched case. Count state left over after a disable or a pause would show only on the next start, as a shortened delay. Mid-count interruptions are followed by a full-length restart check for this reason. A wrong synchroniser depth shifts status_stable by whole register edges, which the per-cycle comparison catches within two edges.

// File: rtl/osc_startup_pkg.sv
package osc_startup_pkg;

    localparam int DATA_W      = 32;
    localparam int DELAY_W     = 14;
    localparam int X4_BIT      = 20;
    localparam int PRESC_W     = 8;
    localparam int UNIT_W      = DELAY_W + 2;
    localparam logic [DELAY_W-1:0] DELAY_RESET = DELAY_W'(196);

    typedef struct packed {
        logic               x4;
        logic [DELAY_W-1:0] delay;
    } startup_cfg_t;

    // Number of whole prescaler units to wait; zero is treated as one.
    function automatic logic [UNIT_W-1:0] unit_target(input startup_cfg_t c);
        logic [UNIT_W-1:0] t;
        t = c.x4 ? {c.delay, 2'b00} : {2'b00, c.delay};
        return (t == '0) ? UNIT_W'(1) : t;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cfg(input startup_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DELAY_W-1:0] = c.delay;
        w[X4_BIT]      = c.x4;
        return w;
    endfunction

endpackage

// File: rtl/ost_cfg_reg.sv
module ost_cfg_reg
    import osc_startup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output startup_cfg_t      cfg
);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[DATA_W-1:X4_BIT+1], wdata[X4_BIT-1:DELAY_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.delay <= DELAY_RESET;
            cfg.x4    <= 1'b0;
        end else if (we) begin
            cfg.delay <= wdata[DELAY_W-1:0];
            cfg.x4    <= wdata[X4_BIT];
        end
    end

endmodule

// File: rtl/ost_delay_counter.sv
module ost_delay_counter
    import osc_startup_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  startup_cfg_t cfg,
    output logic         stable
);

    logic [PRESC_W-1:0] presc;
    logic [UNIT_W-1:0]  units;
    logic [UNIT_W-1:0]  target;
    logic               unit_done;
    logic [UNIT_W:0]    units_next;

    assign target     = unit_target(cfg);
    assign unit_done  = (presc == {PRESC_W{1'b1}});
    assign units_next = {1'b0, units} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            presc  <= '0;
            units  <= '0;
            stable <= 1'b0;
        end else if (!stable) begin
            presc <= presc + 1'b1;
            if (unit_done) begin
                units <= units_next[UNIT_W-1:0];
                if (units_next == {1'b0, target})
                    stable <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ost_sync.sv
module ost_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer
    import osc_startup_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              reg_clk,
    input  logic              reg_rst,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              status_stable,
    input  logic              osc_clk,
    input  logic              osc_rst,
    input  logic              osc_enable,
    input  logic              osc_pause,
    output logic              osc_stable
);

    startup_cfg_t cfg;
    logic         run;

    assign run       = osc_enable & ~osc_pause;
    assign cfg_rdata = pack_cfg(cfg);

    ost_cfg_reg u_cfg (
        .clk   (reg_clk),
        .rst   (reg_rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    ost_delay_counter u_cnt (
        .clk    (osc_clk),
        .rst    (osc_rst),
        .run    (run),
        .cfg    (cfg),
        .stable (osc_stable)
    );

    ost_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (reg_clk),
        .rst (reg_rst),
        .d   (osc_stable),
        .q   (status_stable)
    );

endmodule

// File: rtl/ost_checker.sv
module ost_checker
    import osc_startup_pkg::*;
(
    input logic              reg_clk,
    input logic              reg_rst,
    input logic              cfg_we,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              status_stable,
    input logic              osc_clk,
    input logic              osc_rst,
    input logic              osc_enable,
    input logic              osc_pause,
    input logic              osc_stable
);

    logic unused_chk;
    assign unused_chk = status_stable;

    AST_RESET_CFG: assert property (@(posedge reg_clk) reg_rst |=> (cfg_rdata == 32'h0000_00C4)); // R1

    AST_WRITE_LOADS: assert property (@(posedge reg_clk) disable iff (reg_rst)
        cfg_we |=> (cfg_rdata[DELAY_W-1:0] == $past(cfg_wdata[DELAY_W-1:0]) &&
                    cfg_rdata[X4_BIT] == $past(cfg_wdata[X4_BIT]))); // R2

    AST_OFF_CLEARS: assert property (@(posedge osc_clk) disable iff (osc_rst)
        !osc_enable |=> !osc_stable); // R6

    AST_PAUSE_CLEARS: assert property (@(posedge osc_clk) disable iff (osc_rst)
        osc_pause |=> !osc_stable); // R7

    AST_STABLE_HOLDS: assert property (@(posedge osc_clk) disable iff (osc_rst)
        (osc_stable && osc_enable && !osc_pause) |=> osc_stable); // R8

endmodule

bind osc_startup_timer ost_checker u_chk (.*);

// File: tb/test_osc_startup_timer.sv
module test_osc_startup_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        st_sync;
    logic        enable = 1'b0;
    logic        pause = 1'b0;
    logic        st_osc;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    osc_startup_timer i_osc_startup_timer (
        .reg_clk       (clk),
        .reg_rst       (rst),
        .cfg_we        (we),
        .cfg_wdata     (wdata),
        .cfg_rdata     (rdata),
        .status_stable (st_sync),
        .osc_clk       (clk),
        .osc_rst       (rst),
        .osc_enable    (enable),
        .osc_pause     (pause),
        .osc_stable    (st_osc)
    );

    // behavioural reference model
    int m_delay = 196;
    bit m_x4 = 1'b0;
    int m_cnt = 0;
    bit m_st = 1'b0;
    bit m_q1 = 1'b0, m_q2 = 1'b0;

    always @(posedge clk) begin
        int tgt;
        tgt = m_x4 ? m_delay * 4 : m_delay;
        if (tgt == 0) tgt = 1;
        if (rst) begin m_q2 = 0; m_q1 = 0; end
        else begin m_q2 = m_q1; m_q1 = m_st; end
        if (rst || !enable || pause) begin m_cnt = 0; m_st = 0; end
        else if (!m_st) begin
            m_cnt++;
            if (m_cnt == 256 * tgt) m_st = 1;
        end
        if (rst) begin m_delay = 196; m_x4 = 0; end
        else if (we) begin m_delay = int'(wdata[13:0]); m_x4 = wdata[20]; end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [31:0] exp_r;
            exp_r = '0;
            exp_r[13:0] = m_delay[13:0];
            exp_r[20] = m_x4;
            vectors++;
            if (st_osc !== m_st) begin
                fails++;
                $display("FAIL R3 model osc_stable got %b exp %b at %0t", st_osc, m_st, $time);
            end
            if (st_sync !== m_q2) begin
                fails++;
                $display("FAIL R9 model status_stable got %b exp %b at %0t", st_sync, m_q2, $time);
            end
            if (rdata !== exp_r) begin
                fails++;
                $display("FAIL R2 model cfg_rdata got %h exp %h at %0t", rdata, exp_r, $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        we = 1'b1; wdata = w;
        tick(1);
        we = 1'b0; wdata = '0;
    endtask

    // enable, then check low one edge before N and high at N
    task automatic run_to(input int n, input string req);
        enable = 1'b1; pause = 1'b0;
        tick(n - 1);
        chk({31'b0, st_osc}, 32'd0, req);
        tick(1);
        chk({31'b0, st_osc}, 32'd1, req);
    endtask

    task automatic summary;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        chk(rdata, 32'h0000_00C4, "R1 reset config");
        chk({31'b0, st_osc}, 32'd0, "R1 reset stable");
        chk({31'b0, st_sync}, 32'd0, "R9 reset status");

        // R3 default delay 196 units
        run_to(196 * 256, "R3 default delay");
        tick(1);
        chk({31'b0, st_sync}, 32'd0, "R9 first sync edge");
        tick(1);
        chk({31'b0, st_sync}, 32'd1, "R9 second sync edge");
        tick(300);
        chk({31'b0, st_osc}, 32'd1, "R8 holds");

        // R6 disable clears
        enable = 1'b0;
        tick(1);
        chk({31'b0, st_osc}, 32'd0, "R6 disable clears");
        tick(2);
        chk({31'b0, st_sync}, 32'd0, "R9 clear synced");

        // R2 write with junk bits
        write_cfg(32'hFFEF_0003);
        chk(rdata, 32'h0000_0003, "R2 ignored bits");
        run_to(768, "R3 delay 3");

        // R7 pause after stable, then mid-count pause
        pause = 1'b1;
        tick(1);
        chk({31'b0, st_osc}, 32'd0, "R7 pause clears");
        pause = 1'b0;
        tick(500);
        pause = 1'b1;
        tick(1);
        run_to(768, "R7 full restart after pause");

        // R5 zero delay, both stretch settings
        enable = 1'b0;
        write_cfg(32'h0000_0000);
        run_to(256, "R5 zero delay");
        enable = 1'b0;
        write_cfg(32'h0010_0000);
        chk(rdata, 32'h0010_0000, "R2 stretch bit only");
        run_to(256, "R5 zero delay stretched");

        // R4 stretch x4
        enable = 1'b0;
        write_cfg(32'h0010_0002);
        chk(rdata, 32'h0010_0002, "R2 stretch readback");
        run_to(2048, "R4 stretched delay");

        // R6 mid-count disable then full restart
        enable = 1'b0;
        tick(2);
        enable = 1'b1;
        tick(1000);
        enable = 1'b0;
        tick(1);
        run_to(2048, "R6 full restart after disable");

        tick(4);
        summary();
    end

endmodule